// File: doc/BRIEF.md
# I2C Slave Address Responder

This block is the target side of a two-wire serial bus port. After reset it listens in slave-receive mode. It watches the synchronized clock and data lines for a start condition, then shifts in the address byte that follows. The upper seven bits of that byte are compared with a programmable own address. The all-zero general-call byte is also accepted. On a hit the block pulls the data line low during the ninth clock to acknowledge. The least significant bit of the address byte then chooses its role: 0 keeps it receiving, and 1 makes it transmit.

In receive mode, each completed byte is presented to the host on `rx_data` with a one-cycle `rx_valid` strobe, and the block acknowledges it. In transmit mode, the block samples `tx_data` at the start of each byte and marks that sample with `tx_taken`. It shifts the byte out MSB first and keeps going while the master acknowledges. A master NACK, a stop condition or a new start condition returns it to receive mode and restarts address detection. The data line is driven open-drain through `sda_oe`: a high `sda_oe` pulls the line low.

Top module: `i2c_addr_responder`

## Requirements
- R1: After reset the block is in slave-receive mode (`mode_tx`=0), `sda_oe`=0, both hit flags are 0 and `rx_valid`=0.
- R2: A start condition is SDA falling while SCL is high, and only a start condition begins address detection. An address byte sent without a preceding start gets no acknowledge.
- R3: An address byte whose bits [7:1] equal `own_addr` is acknowledged: `sda_oe` rises only while SCL is low and holds SDA low through the high phase of the ninth clock. `own_hit` reads 1.
- R4: The address byte 0x00 is a general-call match and is acknowledged with `gc_hit`=1 and `own_hit`=0, even when `own_addr` is 0. The two flags are never both 1.
- R5: On an address mismatch no acknowledge is given, and all bytes that follow are ignored (no acknowledge, no `rx_valid`) until the next start condition.
- R6: Bit 0 of a matched address byte is the direction. A value of 0 leaves `mode_tx`=0 and a value of 1 sets `mode_tx`=1.
- R7: In receive mode each data byte is shifted in MSB first, appears on `rx_data` with one `rx_valid` pulse, and is acknowledged in the ninth clock.
- R8: In transmit mode the block samples `tx_data` with a `tx_taken` pulse after the address acknowledge and after each master ACK (SDA low on the ninth clock), and drives it MSB first, changing SDA only while SCL is low.
- R9: A master NACK (SDA high on the ninth clock of a transmitted byte) returns the block to receive mode with SDA released, and it ignores the bus until the next start.
- R10: A stop condition (SDA rising while SCL is high) or a new start condition at any point aborts the current byte and clears `mode_tx` and the hit flags. A new start then restarts address detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 7 | Programmed own address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| tx_data | input | 8 | Byte to transmit in transmit mode |
| tx_taken | output | 1 | One-cycle pulse when `tx_data` is sampled |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| mode_tx | output | 1 | 1 = slave-transmit, 0 = slave-receive |
| gc_hit | output | 1 | Current transfer was addressed by general call |
| own_hit | output | 1 | Current transfer was addressed by own address |

## Verification
The bench covers several address edge cases. These include an own address of zero, where the read byte 0x01 must count as an own hit while 0x00 must still report general call. They also include an all-ones address, and addresses that differ from the programmed one by one bit. A matcher that compared the wrong bit slice, or that gave the general call no priority, would show the wrong ACK or flag here. After a mismatch, the bench sends a byte equal to the correct address without a new start. A responder that restarted its address search on any byte would acknowledge it. A read sequence with a master ACK and then a NACK checks that the second byte is sampled afresh and that the block leaves transmit mode. Aborts by start and by stop in the middle of an address test that partial bits are discarded.

// File: rtl/i2c_resp_pkg.sv
package i2c_resp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_SETUP,
        ST_ACK_DRIVE,
        ST_RX,
        ST_TX,
        ST_TX_MACK
    } resp_state_e;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_OWN,
        HIT_GC
    } hit_e;

    // Bus events derived from synchronized lines, one cycle wide
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic hit_is(hit_e h, hit_e kind);
        return h == kind;
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_resp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_sync,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] line_in;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] last_q;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= '1;
            else     ff <= {ff[STAGES-2:0], line_in[g]};
        end
        assign synced[g] = ff[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= '1;
        else     last_q <= synced;
    end

    logic scl_now, sda_now, scl_was, sda_was;
    assign scl_now = synced[0];
    assign sda_now = synced[1];
    assign scl_was = last_q[0];
    assign sda_was = last_q[1];

    always_comb begin
        ev.start = scl_now && scl_was && sda_was && !sda_now;
        ev.stop  = scl_now && scl_was && !sda_was && sda_now;
        ev.rise  = scl_now && !scl_was;
        ev.fall  = !scl_now && scl_was;
        ev.sda   = sda_now;
    end

    assign scl_sync = scl_now;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_resp_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   cand,
    input  logic [ADDR_W-1:0] own_addr,
    output hit_e              hit
);
    always_comb begin
        if (cand == '0)
            hit = HIT_GC;
        else if (cand[ADDR_W:1] == own_addr)
            hit = HIT_OWN;
        else
            hit = HIT_NONE;
    end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_resp_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  hit_e              hit_in,
    output logic [ADDR_W:0]   cand,
    input  logic [ADDR_W:0]   tx_data,
    output logic              tx_taken,
    output logic [ADDR_W:0]   rx_data,
    output logic              rx_valid,
    output logic              sda_oe,
    output logic              mode_tx,
    output hit_e              hit_q
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    resp_state_e       state_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    assign cand = {shreg_q[BYTE_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            shreg_q  <= '0;
            cnt_q    <= '0;
            sda_oe   <= 1'b0;
            mode_tx  <= 1'b0;
            hit_q    <= HIT_NONE;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            tx_taken <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_taken <= 1'b0;
            if (ev.stop) begin
                state_q <= ST_IDLE;
                sda_oe  <= 1'b0;
                mode_tx <= 1'b0;
                hit_q   <= HIT_NONE;
            end else if (ev.start) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
                sda_oe  <= 1'b0;
                mode_tx <= 1'b0;
                hit_q   <= HIT_NONE;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (ev.rise) begin
                            shreg_q <= cand;
                            cnt_q   <= cnt_q + 1'b1;
                            if (cnt_q == LAST_BIT) begin
                                if (hit_in != HIT_NONE) begin
                                    hit_q   <= hit_in;
                                    mode_tx <= ev.sda;
                                    state_q <= ST_ACK_SETUP;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                        end
                    end
                    ST_ACK_SETUP: begin
                        if (ev.fall) begin
                            sda_oe  <= 1'b1;
                            state_q <= ST_ACK_DRIVE;
                        end
                    end
                    ST_ACK_DRIVE: begin
                        if (ev.fall) begin
                            cnt_q <= '0;
                            if (mode_tx) begin
                                shreg_q  <= tx_data;
                                sda_oe   <= ~tx_data[BYTE_W-1];
                                tx_taken <= 1'b1;
                                state_q  <= ST_TX;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_RX;
                            end
                        end
                    end
                    ST_RX: begin
                        if (ev.rise) begin
                            shreg_q <= cand;
                            cnt_q   <= cnt_q + 1'b1;
                            if (cnt_q == LAST_BIT) begin
                                rx_data  <= cand;
                                rx_valid <= 1'b1;
                                state_q  <= ST_ACK_SETUP;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (ev.fall) begin
                            if (cnt_q == ALL_BITS) begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_TX_MACK;
                            end else begin
                                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~shreg_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_MACK: begin
                        if (ev.rise) begin
                            if (ev.sda) begin
                                mode_tx <= 1'b0;
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_ACK_DRIVE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_addr_responder.sv
module i2c_addr_responder
    import i2c_resp_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W:0]   tx_data,
    output logic              tx_taken,
    output logic [ADDR_W:0]   rx_data,
    output logic              rx_valid,
    output logic              mode_tx,
    output logic              gc_hit,
    output logic              own_hit
);
    bus_ev_t         bus_ev;
    logic            scl_sync;
    logic [ADDR_W:0] cand;
    hit_e            hit_now;
    hit_e            hit_q;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_sync (scl_sync),
        .ev       (bus_ev)
    );

    i2c_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .cand     (cand),
        .own_addr (own_addr),
        .hit      (hit_now)
    );

    i2c_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (bus_ev),
        .hit_in   (hit_now),
        .cand     (cand),
        .tx_data  (tx_data),
        .tx_taken (tx_taken),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .sda_oe   (sda_oe),
        .mode_tx  (mode_tx),
        .hit_q    (hit_q)
    );

    assign gc_hit  = hit_is(hit_q, HIT_GC);
    assign own_hit = hit_is(hit_q, HIT_OWN);

endmodule

// File: rtl/i2c_resp_chk.sv
module i2c_resp_chk (
    input logic clk,
    input logic rst,
    input logic scl_sync,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic mode_tx,
    input logic gc_hit,
    input logic own_hit,
    input logic rx_valid,
    input logic tx_taken
);
    p_rx_mode_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!mode_tx && !sda_oe && !gc_hit && !own_hit && !rx_valid));

    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (!mode_tx && !gc_hit && !own_hit && !sda_oe));

    p_drive_on_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_sync));

    p_hit_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(gc_hit && own_hit));

    p_rx_in_receive_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !mode_tx);

    p_load_in_transmit_r8: assert property (@(posedge clk) disable iff (rst)
        tx_taken |-> mode_tx);

    p_stop_releases_r10: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!sda_oe && !mode_tx && !gc_hit && !own_hit));
endmodule

bind i2c_addr_responder i2c_resp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_sync  (scl_sync),
    .start_det (bus_ev.start),
    .stop_det  (bus_ev.stop),
    .sda_oe    (sda_oe),
    .mode_tx   (mode_tx),
    .gc_hit    (gc_hit),
    .own_hit   (own_hit),
    .rx_valid  (rx_valid),
    .tx_taken  (tx_taken)
);

// File: tb/tb_i2c_addr_responder.sv
`timescale 1ns/1ps
module tb_i2c_addr_responder;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] own_addr = 7'h50;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] tx_data = 8'hFF;
    logic       tx_taken;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       mode_tx;
    logic       gc_hit;
    logic       own_hit;

    int checks = 0;
    int errors = 0;
    int rx_cnt = 0;
    int tx_cnt = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_addr_responder dut (
        .clk      (clk),
        .rst      (rst),
        .own_addr (own_addr),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .tx_data  (tx_data),
        .tx_taken (tx_taken),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .mode_tx  (mode_tx),
        .gc_hit   (gc_hit),
        .own_hit  (own_hit)
    );

    always @(posedge clk) begin
        if (rx_valid) rx_cnt++;
        if (tx_taken) tx_cnt++;
    end

    // {own_addr[6:0], addr_byte[7:0], ack, gc, own, tx}
    localparam int NV = 9;
    localparam logic [18:0] VEC [NV] = '{
        {7'h50, 8'hA0, 1'b1, 1'b0, 1'b1, 1'b0},
        {7'h50, 8'hA1, 1'b1, 1'b0, 1'b1, 1'b1},
        {7'h50, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        {7'h50, 8'hA2, 1'b0, 1'b0, 1'b0, 1'b0},
        {7'h7F, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1},
        {7'h00, 8'h01, 1'b1, 1'b0, 1'b1, 1'b1},
        {7'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        {7'h2A, 8'h54, 1'b1, 1'b0, 1'b1, 1'b0},
        {7'h2A, 8'hD4, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_c();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic stop_c();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq();
            m_scl = 1'b1; wq();
            v[i] = sda_line; wq();
            m_scl = 1'b0; wq();
        end
    endtask

    // ninth clock with the master released; samples ack and status mid-high
    task automatic ack_phase(output logic ack, output logic g, output logic o, output logic t);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = ~sda_line;
        g = gc_hit; o = own_hit; t = mode_tx;
        wq();
        m_scl = 1'b0; wq();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a, g, o, t;
        logic [7:0] rb;
        int rx0, tx0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode_tx", mode_tx, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 gc_hit", gc_hit, 0);
        chk("R1 own_hit", own_hit, 0);
        chk("R1 rx_valid", rx_valid, 0);
        wq();

        // table: R3 R4 R6 address matching and direction
        tx_data = 8'hFF;
        for (int k = 0; k < NV; k++) begin
            own_addr = VEC[k][18:12];
            start_c();
            put_byte(VEC[k][11:4]);
            ack_phase(a, g, o, t);
            chk($sformatf("R3 ack vec%0d", k), a, VEC[k][3]);
            chk($sformatf("R4 gc vec%0d", k), g, VEC[k][2]);
            chk($sformatf("R3 own vec%0d", k), o, VEC[k][1]);
            chk($sformatf("R6 dir vec%0d", k), t, VEC[k][0]);
            stop_c();
            wq();
            chk($sformatf("R10 stop clears mode vec%0d", k), mode_tx, 0);
        end

        // R7 receive two data bytes
        own_addr = 7'h50;
        start_c();
        put_byte(8'hA0);
        ack_phase(a, g, o, t);
        chk("R7 addr ack", a, 1);
        rx0 = rx_cnt;
        put_byte(8'h3C);
        ack_phase(a, g, o, t);
        chk("R7 data ack", a, 1);
        chk("R7 rx_data byte1", rx_data, 8'h3C);
        put_byte(8'hC5);
        ack_phase(a, g, o, t);
        chk("R7 data ack2", a, 1);
        chk("R7 rx_data byte2", rx_data, 8'hC5);
        chk("R7 rx_valid count", rx_cnt - rx0, 2);
        stop_c(); wq();

        // R8 R9 transmit with master ACK then NACK
        tx_data = 8'h96;
        tx0 = tx_cnt;
        start_c();
        put_byte(8'hA1);
        ack_phase(a, g, o, t);
        chk("R8 addr ack", a, 1);
        chk("R6 read mode", t, 1);
        get_byte(rb);
        chk("R8 tx byte1", rb, 8'h96);
        tx_data = 8'h5A;
        put_bit(1'b0);
        get_byte(rb);
        chk("R8 tx byte2", rb, 8'h5A);
        chk("R8 tx_taken count", tx_cnt - tx0, 2);
        put_bit(1'b1);
        chk("R9 mode after nack", mode_tx, 0);
        chk("R9 sda released", sda_oe, 0);
        rx0 = rx_cnt;
        put_byte(8'hA0);
        ack_phase(a, g, o, t);
        chk("R9 ignored after nack", a, 0);
        chk("R9 no rx after nack", rx_cnt - rx0, 0);
        stop_c(); wq();

        // R5 mismatch then own address without start
        start_c();
        put_byte(8'hA4);
        ack_phase(a, g, o, t);
        chk("R5 mismatch no ack", a, 0);
        rx0 = rx_cnt;
        put_byte(8'hA0);
        ack_phase(a, g, o, t);
        chk("R5 later byte ignored", a, 0);
        chk("R5 no rx_valid", rx_cnt - rx0, 0);
        stop_c(); wq();

        // R2 address without start after idle
        put_byte(8'hA0);
        ack_phase(a, g, o, t);
        chk("R2 no start no ack", a, 0);
        stop_c(); wq();

        // R10 repeated start mid-address
        start_c();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        start_c();
        put_byte(8'hA0);
        ack_phase(a, g, o, t);
        chk("R10 restart ack", a, 1);
        chk("R10 restart own", o, 1);
        stop_c(); wq();

        // R10 stop mid-address discards partial bits
        start_c();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        stop_c(); wq();
        chk("R10 stop flags", {gc_hit, own_hit, mode_tx}, 3'b000);
        put_byte(8'hA0);
        ack_phase(a, g, o, t);
        chk("R10 stop then no start", a, 0);
        stop_c(); wq();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule